// File: doc/BRIEF.md
# Overlapped Translation and Cache Lookup

This block serves a CPU load with one lookup that reads the address translator and the cache in the same cycle, so translation costs no extra cycle. The cache is direct mapped and physically tagged. It is indexed only with bits of the virtual address that lie inside the page offset, and those bits pass through translation unchanged. While the line is being read, a small fully associative translation buffer turns the virtual page number into a physical page number. The block then compares that physical page number with the tag stored in the line.

The block registers one of three outcomes for each request, one cycle later:
- The cached word, when the translation hits and the line holds that physical page.
- A main-memory request carrying the translated physical address, when the translation hits but the line is empty or holds another page.
- A request for a full translation of the page, when the translation buffer has no entry for it.

Two write ports load translation entries and cache lines, so the lookup has contents to work on. The refill traffic behind them lies outside the block. Elaboration stops with an error when the cache span would reach past the page offset, because overlapped indexing is only sound when it does not.

Top module: `vlk_overlap_lookup`

## Requirements
- R1: Reset clears every translation entry and every cache line valid bit, and holds rsp_valid, mem_req and xlate_req low. The first request after reset therefore yields xlate_req.
- R2: A request with cpu_req high in cycle N raises exactly one of rsp_valid, mem_req, xlate_req in cycle N+1. A cycle with cpu_req low raises none of them in the following cycle.
- R3: When the translation hits and the indexed line is valid with a stored tag equal to the physical page number, rsp_valid is raised and rsp_data carries the stored word.
- R4: When the translation hits but the line is invalid or its tag differs, mem_req is raised with mem_paddr = {physical page, cpu_vaddr[11:0]}.
- R5: When no valid translation entry matches cpu_vaddr[31:12], xlate_req is raised with xlate_vpn = cpu_vaddr[31:12], whatever the cache line holds.
- R6: The line index is cpu_vaddr[11:2]. Bits [1:0] do not select the line, and rsp_data is the whole 32-bit word.
- R7: A translation write with tlb_wr_valid low removes that slot's mapping, so later requests to that page yield xlate_req.
- R8: A translation write or a line fill in the same cycle as a request is not visible to that request. It is visible to the next one.
- R9: A fill replaces the line's tag and data. A request whose page maps to the old tag then yields mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Lookup request this cycle |
| cpu_vaddr | input | 32 | Virtual byte address of the request |
| tlb_wr_en | input | 1 | Write one translation slot |
| tlb_wr_slot | input | 3 | Slot number written |
| tlb_wr_valid | input | 1 | Valid bit written into the slot |
| tlb_wr_vpn | input | 20 | Virtual page number written |
| tlb_wr_ppn | input | 20 | Physical page number written |
| fill_en | input | 1 | Write one cache line |
| fill_paddr | input | 32 | Physical address of the line written (index from [11:2], tag from [31:12]) |
| fill_data | input | 32 | Word written into the line |
| rsp_valid | output | 1 | Cached word returned |
| rsp_data | output | 32 | Returned word |
| mem_req | output | 1 | Main-memory access needed |
| mem_paddr | output | 32 | Translated physical address for the access |
| xlate_req | output | 1 | Full translation needed |
| xlate_vpn | output | 20 | Virtual page number to translate |

## Verification
A request can arrive in the same cycle as a line fill to the line it indexes, or as a translation write for the page it carries. In that cycle the lookup and the update compete for the same storage. The bench drives each pairing in one cycle. It expects the request to see the old contents: mem_req for a fill, xlate_req for a translation write. It then issues the same request again and expects the new contents: the filled word, or a memory access at the new physical page. The table-driven part also separates tag mismatch from empty line and translation miss on one shared index. This confirms that the three-way priority picks the right outcome when several conditions hold together.

// File: rtl/vlk_pkg.sv
package vlk_pkg;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_DATA  = 2'd1,
        RES_MEM   = 2'd2,
        RES_XLATE = 2'd3
    } result_e;

    // Priority: cached word, then memory with translated address, then full walk.
    function automatic result_e pick_result(input logic req,
                                            input logic xl_hit,
                                            input logic line_ok,
                                            input logic tag_eq);
        if (!req)                       return RES_NONE;
        if (xl_hit && line_ok && tag_eq) return RES_DATA;
        if (xl_hit)                     return RES_MEM;
        return RES_XLATE;
    endfunction

endpackage

// File: rtl/vlk_tlb.sv
module vlk_tlb #(
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 8,
    parameter int SLOT_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn
);
    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    slot_t [ENTRIES-1:0] slots_d, slots_q;
    logic  [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = slots_q[e].valid && (slots_q[e].vpn == lk_vpn);
    end

    always_comb begin
        slots_d = slots_q;
        if (wr_en) begin
            slots_d[wr_slot].valid = wr_valid;
            slots_d[wr_slot].vpn   = wr_vpn;
            slots_d[wr_slot].ppn   = wr_ppn;
        end
    end

    always_comb begin
        lk_ppn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) lk_ppn = lk_ppn | slots_q[e].ppn;
        end
    end

    assign lk_hit = |match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slots_q <= '0;
        else        slots_q <= slots_d;
    end
endmodule

// File: rtl/vlk_line_store.sv
module vlk_line_store #(
    parameter int LINES  = 1024,
    parameter int IDX_W  = $clog2(LINES),
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_word
);
    logic [LINES-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] word_q [LINES];

    always_comb begin
        valid_d = valid_q;
        if (fill_en) valid_d[fill_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // Tag and data need no reset: the valid bit gates every use.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            word_q[fill_idx] <= fill_word;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_word  = word_q[rd_idx];
endmodule

// File: rtl/vlk_resolve.sv
module vlk_resolve #(
    parameter int PPN_W = 20
) (
    input  logic             req,
    input  logic             xl_hit,
    input  logic [PPN_W-1:0] xl_ppn,
    input  logic             line_valid,
    input  logic [PPN_W-1:0] line_tag,
    output vlk_pkg::result_e result
);
    logic tag_eq;
    assign tag_eq = (line_tag == xl_ppn);
    assign result = vlk_pkg::pick_result(req, xl_hit, line_valid, tag_eq);
endmodule

// File: rtl/vlk_overlap_lookup.sv
module vlk_overlap_lookup #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_OFF_W  = 12,
    parameter int CACHE_BYTES = 4096,
    parameter int LINE_BYTES  = 4,
    parameter int TLB_ENTRIES = 8,
    parameter int SLOT_W      = $clog2(TLB_ENTRIES),
    parameter int VPN_W       = ADDR_W - PAGE_OFF_W,
    parameter int DATA_W      = 8 * LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_vaddr,
    input  logic              tlb_wr_en,
    input  logic [SLOT_W-1:0] tlb_wr_slot,
    input  logic              tlb_wr_valid,
    input  logic [VPN_W-1:0]  tlb_wr_vpn,
    input  logic [VPN_W-1:0]  tlb_wr_ppn,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_paddr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_paddr,
    output logic              xlate_req,
    output logic [VPN_W-1:0]  xlate_vpn
);
    import vlk_pkg::*;

    localparam int PAGE_BYTES = 1 << PAGE_OFF_W;
    localparam int LINES      = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W      = $clog2(LINES);
    localparam int BOFF_W     = $clog2(LINE_BYTES);

    // Overlap is only sound while the whole index sits in the page offset.
    if (CACHE_BYTES > PAGE_BYTES) begin : g_bad_geometry
        $error("cache span exceeds page size: index bits would be translated");
    end

    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic              mem_req;
        logic [ADDR_W-1:0] mem_paddr;
        logic              xlate_req;
        logic [VPN_W-1:0]  xlate_vpn;
    } out_t;

    out_t              out_d, out_q;
    logic              xl_hit;
    logic [VPN_W-1:0]  xl_ppn;
    logic              line_valid;
    logic [VPN_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_word;
    result_e           result;

    vlk_tlb #(
        .VPN_W  (VPN_W),
        .PPN_W  (VPN_W),
        .ENTRIES(TLB_ENTRIES),
        .SLOT_W (SLOT_W)
    ) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tlb_wr_en),
        .wr_slot (tlb_wr_slot),
        .wr_valid(tlb_wr_valid),
        .wr_vpn  (tlb_wr_vpn),
        .wr_ppn  (tlb_wr_ppn),
        .lk_vpn  (cpu_vaddr[ADDR_W-1:PAGE_OFF_W]),
        .lk_hit  (xl_hit),
        .lk_ppn  (xl_ppn)
    );

    vlk_line_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (VPN_W),
        .DATA_W(DATA_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_en),
        .fill_idx (fill_paddr[BOFF_W +: IDX_W]),
        .fill_tag (fill_paddr[ADDR_W-1:PAGE_OFF_W]),
        .fill_word(fill_data),
        .rd_idx   (cpu_vaddr[BOFF_W +: IDX_W]),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_word  (line_word)
    );

    vlk_resolve #(
        .PPN_W(VPN_W)
    ) u_resolve (
        .req       (cpu_req),
        .xl_hit    (xl_hit),
        .xl_ppn    (xl_ppn),
        .line_valid(line_valid),
        .line_tag  (line_tag),
        .result    (result)
    );

    always_comb begin
        out_d = '0;
        unique case (result)
            RES_DATA: begin
                out_d.rsp_valid = 1'b1;
                out_d.rsp_data  = line_word;
            end
            RES_MEM: begin
                out_d.mem_req   = 1'b1;
                out_d.mem_paddr = {xl_ppn, cpu_vaddr[PAGE_OFF_W-1:0]};
            end
            RES_XLATE: begin
                out_d.xlate_req = 1'b1;
                out_d.xlate_vpn = cpu_vaddr[ADDR_W-1:PAGE_OFF_W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid = out_q.rsp_valid;
    assign rsp_data  = out_q.rsp_data;
    assign mem_req   = out_q.mem_req;
    assign mem_paddr = out_q.mem_paddr;
    assign xlate_req = out_q.xlate_req;
    assign xlate_vpn = out_q.xlate_vpn;
endmodule

// File: rtl/vlk_overlap_checker.sv
module vlk_overlap_checker #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_OFF_W = 12,
    parameter int VPN_W      = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_vaddr,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_paddr,
    input logic              xlate_req,
    input logic [VPN_W-1:0]  xlate_vpn
);
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |=> ($countones({rsp_valid, mem_req, xlate_req}) == 1));

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |=> !(rsp_valid || mem_req || xlate_req));

    assert_never_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, mem_req, xlate_req}));

    assert_mem_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_paddr[PAGE_OFF_W-1:0] == $past(cpu_vaddr[PAGE_OFF_W-1:0])));

    assert_xlate_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_req |-> (xlate_vpn == $past(cpu_vaddr[ADDR_W-1:PAGE_OFF_W])));
endmodule

bind vlk_overlap_lookup vlk_overlap_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_OFF_W(PAGE_OFF_W),
    .VPN_W     (VPN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_vaddr(cpu_vaddr),
    .rsp_valid(rsp_valid),
    .mem_req  (mem_req),
    .mem_paddr(mem_paddr),
    .xlate_req(xlate_req),
    .xlate_vpn(xlate_vpn)
);

// File: tb/vlk_overlap_lookup_tb.sv
module vlk_overlap_lookup_tb;

    localparam logic [1:0] OP_NOP = 2'd0, OP_LOOK = 2'd1, OP_TLBW = 2'd2, OP_FILL = 2'd3;
    localparam logic [1:0] EX_NONE = 2'd0, EX_DATA = 2'd1, EX_MEM = 2'd2, EX_XL = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;     // vaddr, vpn or fill paddr
        logic [31:0] b;     // ppn or fill data
        logic [2:0]  slot;
        logic        vld;
        logic [1:0]  ex;
        logic [31:0] exv;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{OP_LOOK, 32'h12345010, 32'h0,        3'd0, 1'b0, EX_XL,   32'h00012345, 4'd1}, // R1 empty after reset
        '{OP_TLBW, 32'h00012345, 32'h00000ABC, 3'd0, 1'b1, EX_NONE, 32'h0,        4'd2}, // R2 no request
        '{OP_LOOK, 32'h12345010, 32'h0,        3'd0, 1'b0, EX_MEM,  32'h00ABC010, 4'd4}, // R4 line invalid
        '{OP_FILL, 32'h00ABC010, 32'hDEADBEEF, 3'd0, 1'b0, EX_NONE, 32'h0,        4'd2},
        '{OP_LOOK, 32'h12345010, 32'h0,        3'd0, 1'b0, EX_DATA, 32'hDEADBEEF, 4'd3}, // R3 hit
        '{OP_LOOK, 32'h12345013, 32'h0,        3'd0, 1'b0, EX_DATA, 32'hDEADBEEF, 4'd6}, // R6 byte bits
        '{OP_LOOK, 32'h12345014, 32'h0,        3'd0, 1'b0, EX_MEM,  32'h00ABC014, 4'd6}, // R6 next line
        '{OP_TLBW, 32'h00000001, 32'h0007F001, 3'd1, 1'b1, EX_NONE, 32'h0,        4'd2},
        '{OP_LOOK, 32'h00001010, 32'h0,        3'd0, 1'b0, EX_MEM,  32'h7F001010, 4'd4}, // R4 tag differs
        '{OP_FILL, 32'h7F001010, 32'h0BADF00D, 3'd0, 1'b0, EX_NONE, 32'h0,        4'd2},
        '{OP_LOOK, 32'h00001010, 32'h0,        3'd0, 1'b0, EX_DATA, 32'h0BADF00D, 4'd3},
        '{OP_LOOK, 32'h12345010, 32'h0,        3'd0, 1'b0, EX_MEM,  32'h00ABC010, 4'd9}, // R9 evicted
        '{OP_LOOK, 32'h55555010, 32'h0,        3'd0, 1'b0, EX_XL,   32'h00055555, 4'd5}, // R5 valid line, no entry
        '{OP_TLBW, 32'h000FFFFF, 32'h00000000, 3'd7, 1'b1, EX_NONE, 32'h0,        4'd2},
        '{OP_FILL, 32'h00000FFC, 32'h13579BDF, 3'd0, 1'b0, EX_NONE, 32'h0,        4'd2},
        '{OP_LOOK, 32'hFFFFFFFF, 32'h0,        3'd0, 1'b0, EX_DATA, 32'h13579BDF, 4'd3}, // R3 top page, last line
        '{OP_TLBW, 32'h00000001, 32'h0007F001, 3'd1, 1'b0, EX_NONE, 32'h0,        4'd7},
        '{OP_LOOK, 32'h00001010, 32'h0,        3'd0, 1'b0, EX_XL,   32'h00000001, 4'd7}, // R7 removed
        '{OP_NOP,  32'h0,        32'h0,        3'd0, 1'b0, EX_NONE, 32'h0,        4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [31:0] cpu_vaddr = '0;
    logic        tlb_wr_en = 1'b0;
    logic [2:0]  tlb_wr_slot = '0;
    logic        tlb_wr_valid = 1'b0;
    logic [19:0] tlb_wr_vpn = '0;
    logic [19:0] tlb_wr_ppn = '0;
    logic        fill_en = 1'b0;
    logic [31:0] fill_paddr = '0;
    logic [31:0] fill_data = '0;
    logic        rsp_valid, mem_req, xlate_req;
    logic [31:0] rsp_data, mem_paddr;
    logic [19:0] xlate_vpn;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vlk_overlap_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_vaddr(cpu_vaddr),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_slot(tlb_wr_slot), .tlb_wr_valid(tlb_wr_valid),
        .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
        .fill_en(fill_en), .fill_paddr(fill_paddr), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_req(mem_req),
        .mem_paddr(mem_paddr), .xlate_req(xlate_req), .xlate_vpn(xlate_vpn)
    );

    task automatic idle_inputs();
        cpu_req = 1'b0; tlb_wr_en = 1'b0; fill_en = 1'b0;
    endtask

    task automatic expect_out(input logic [1:0] ex, input logic [31:0] exv, input int rq);
        logic [1:0]  got;
        logic [31:0] gotv;
        int          raised;
        raised = int'(rsp_valid) + int'(mem_req) + int'(xlate_req);
        got  = rsp_valid ? EX_DATA : mem_req ? EX_MEM : xlate_req ? EX_XL : EX_NONE;
        gotv = (got == EX_DATA) ? rsp_data : (got == EX_MEM) ? mem_paddr :
               (got == EX_XL) ? {12'h0, xlate_vpn} : 32'h0;
        checks++;
        if (raised > 1 || got != ex || gotv != exv) begin
            errors++;
            $display("FAIL R%0d: outcome %0d value %h (raised %0d), expected outcome %0d value %h",
                     rq, got, gotv, raised, ex, exv);
        end
    endtask

    task automatic apply(input vec_t v);
        idle_inputs();
        unique case (v.op)
            OP_LOOK: begin cpu_req = 1'b1; cpu_vaddr = v.a; end
            OP_TLBW: begin
                tlb_wr_en = 1'b1; tlb_wr_slot = v.slot; tlb_wr_valid = v.vld;
                tlb_wr_vpn = v.a[19:0]; tlb_wr_ppn = v.b[19:0];
            end
            OP_FILL: begin fill_en = 1'b1; fill_paddr = v.a; fill_data = v.b; end
            default: ;
        endcase
        @(posedge clk); @(negedge clk);
        idle_inputs();
        expect_out(v.ex, v.exv, int'(v.rq));
    endtask

    function automatic vec_t mk(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [2:0] slot, input logic [1:0] ex,
                                input logic [31:0] exv, input logic [3:0] rq);
        vec_t v;
        v = '{op, a, b, slot, 1'b1, ex, exv, rq};
        return v;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: outputs low while reset is held
        repeat (2) @(negedge clk);
        expect_out(EX_NONE, 32'h0, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R8: fill in the same cycle as a request to that line
        cpu_req = 1'b1; cpu_vaddr = 32'h12345020;
        fill_en = 1'b1; fill_paddr = 32'h00ABC020; fill_data = 32'hA5A5C3C3;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        expect_out(EX_MEM, 32'h00ABC020, 8);
        apply(mk(OP_LOOK, 32'h12345020, 32'h0, 3'd0, EX_DATA, 32'hA5A5C3C3, 4'd8));

        // R8: translation write in the same cycle as a request for that page
        cpu_req = 1'b1; cpu_vaddr = 32'h22222000;
        tlb_wr_en = 1'b1; tlb_wr_slot = 3'd2; tlb_wr_valid = 1'b1;
        tlb_wr_vpn = 20'h22222; tlb_wr_ppn = 20'h33333;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        expect_out(EX_XL, 32'h00022222, 8);
        apply(mk(OP_LOOK, 32'h22222000, 32'h0, 3'd0, EX_MEM, 32'h33333000, 4'd8));

        // R1: reset mid-run clears translations and line valid bits
        rst_n = 1'b0;
        @(negedge clk);
        expect_out(EX_NONE, 32'h0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        apply(mk(OP_LOOK, 32'hFFFFFFFF, 32'h0, 3'd0, EX_XL, 32'h000FFFFF, 4'd1));
        apply(mk(OP_TLBW, 32'h000FFFFF, 32'h0, 3'd7, EX_NONE, 32'h0, 4'd2));
        apply(mk(OP_LOOK, 32'hFFFFFFFC, 32'h0, 3'd0, EX_MEM, 32'h00000FFC, 4'd1));

        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule